// File: doc/BRIEF.md
# Backdrop-Aware Video Layer Compositor

This block merges two pixel streams into one output pixel per clock. The base layer comes from a tile-based video generator that reports, along with each pixel, whether that pixel is its backdrop colour, whether the beam is in horizontal or vertical blanking, and whether display output is currently switched on. The overlay layer comes from a frame-buffer generator and carries a per-pixel priority bit.

From the base-layer state the block derives an active-low backdrop indicator. The indicator is asserted for backdrop-colour pixels, for the blanking stretch on either side of each horizontal sync pulse, for all of vertical blanking, and for every line drawn while display is disabled. This can happen in mid-frame when the host turns display off to get free DMA time. The layer decision uses this flag rather than comparing colours. A high-priority overlay pixel always wins. A low-priority overlay pixel still shows wherever the base layer has only backdrop. An overlay pixel with colour value zero is transparent and never wins. Both layers use 9-bit RGB with 3 bits per channel. Pixel, indicator and selection leave the block together, registered once.

Top module: `layer_compositor`

## Requirements
- R1: While rst_n is low, out_pix is 0, bd_n is 1 and out_ovl_sel is 0.
- R2: One clock after a base pixel flagged base_is_bd=1 is presented, bd_n is 0.
- R3: One clock after a cycle with hblank=1, bd_n is 0.
- R4: One clock after a cycle with vblank=1, bd_n is 0.
- R5: One clock after a cycle with disp_en=0, bd_n is 0, whatever the other base inputs are.
- R6: One clock after a cycle with base_is_bd=0, hblank=0, vblank=0 and disp_en=1, bd_n is 1.
- R7: An overlay pixel with ovl_prio=1 and a non-zero value is selected (out_ovl_sel=1, out_pix equals it) one clock later, even when the base pixel is not backdrop.
- R8: An overlay pixel with ovl_prio=0 and a non-zero value is selected one clock later when that cycle's indicator marks the base pixel as backdrop.
- R9: An overlay pixel with ovl_prio=0 and a non-zero value is not selected when the indicator is deasserted; out_pix then equals the base pixel.
- R10: An overlay pixel equal to 9'h000 is transparent. It is never selected, whatever its priority bit, and the base pixel passes through unchanged.
- R11: out_pix, bd_n and out_ovl_sel change together, exactly one clock after their inputs. out_pix equals the overlay pixel of the previous cycle when out_ovl_sel=1, and the base pixel of the previous cycle otherwise. Pixel bits are {R[8:6], G[5:3], B[2:0]}, passed through unaltered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_pix | input | 9 | Base-layer pixel, RGB 3:3:3 |
| base_is_bd | input | 1 | Base pixel is the backdrop colour |
| hblank | input | 1 | Beam in horizontal blanking |
| vblank | input | 1 | Beam in vertical blanking |
| disp_en | input | 1 | Base display output enabled |
| ovl_pix | input | 9 | Overlay pixel, RGB 3:3:3, zero is transparent |
| ovl_prio | input | 1 | Overlay pixel priority |
| out_pix | output | 9 | Composited pixel, registered |
| bd_n | output | 1 | Backdrop indicator, active low, registered |
| out_ovl_sel | output | 1 | 1 when out_pix came from the overlay |

## Verification
Indicator generation and the transparency rule can both act in the same cycle. The tricky cases are a low-priority overlay that is allowed in only because blanking or disabled display forced the indicator, and a zero-valued overlay that would otherwise win through its priority bit or the backdrop. The bench provokes these by presenting overlay pixels during hblank, vblank and display-off cycles, both with and without transparency. It computes its expected pixel, indicator and selection from the requirement text and compares all three one clock later. A free-running stretch of mixed stimulus then checks that the three outputs stay aligned from cycle to cycle.

// File: rtl/comp_pkg.sv
package comp_pkg;

  // Bundle of base-layer state used to derive the backdrop indicator.
  typedef struct packed {
    logic is_bd;
    logic hbl;
    logic vbl;
    logic disp_on;
  } base_state_t;

  // Backdrop is active for the backdrop colour, either blanking, or display off.
  function automatic logic backdrop_active(base_state_t s);
    return s.is_bd | s.hbl | s.vbl | ~s.disp_on;
  endfunction

  // Overlay decision: only opaque pixels compete; priority or backdrop lets them in.
  function automatic logic overlay_wins(logic opaque, logic prio, logic bd);
    return opaque & (prio | bd);
  endfunction

endpackage

// File: rtl/comp_backdrop_gen.sv
module comp_backdrop_gen
  import comp_pkg::*;
(
  input  logic is_bd,
  input  logic hbl,
  input  logic vbl,
  input  logic disp_on,
  output logic bd_now
);
  base_state_t st;

  always_comb begin
    st.is_bd   = is_bd;
    st.hbl     = hbl;
    st.vbl     = vbl;
    st.disp_on = disp_on;
    bd_now     = backdrop_active(st);
  end
endmodule

// File: rtl/comp_layer_sel.sv
module comp_layer_sel
  import comp_pkg::*;
#(
  parameter int CH_W = 3,
  parameter int NCH  = 3,
  localparam int PIX_W = CH_W * NCH
) (
  input  logic [PIX_W-1:0] base_pix,
  input  logic [PIX_W-1:0] ovl_pix,
  input  logic             ovl_prio,
  input  logic             bd_now,
  output logic             opaque,
  output logic             sel_ovl,
  output logic [PIX_W-1:0] mix_pix
);
  always_comb begin
    opaque  = |ovl_pix;
    sel_ovl = overlay_wins(opaque, ovl_prio, bd_now);
  end

  // One mux per colour channel.
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign mix_pix[c*CH_W +: CH_W] = sel_ovl ? ovl_pix[c*CH_W +: CH_W]
                                             : base_pix[c*CH_W +: CH_W];
  end
endmodule

// File: rtl/comp_out_stage.sv
module comp_out_stage #(
  parameter int PIX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] mix_pix,
  input  logic             bd_now,
  input  logic             sel_ovl,
  output logic [PIX_W-1:0] out_pix,
  output logic             bd_n,
  output logic             out_ovl_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_pix     <= '0;
      bd_n        <= 1'b1;
      out_ovl_sel <= 1'b0;
    end else begin
      out_pix     <= mix_pix;
      bd_n        <= ~bd_now;
      out_ovl_sel <= sel_ovl;
    end
  end
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor #(
  parameter int CH_W = 3,
  parameter int NCH  = 3,
  localparam int PIX_W = CH_W * NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] base_pix,
  input  logic             base_is_bd,
  input  logic             hblank,
  input  logic             vblank,
  input  logic             disp_en,
  input  logic [PIX_W-1:0] ovl_pix,
  input  logic             ovl_prio,
  output logic [PIX_W-1:0] out_pix,
  output logic             bd_n,
  output logic             out_ovl_sel
);
  // Named internal events, visible to the checker.
  logic             bd_now;
  logic             ovl_opaque;
  logic             sel_now;
  logic [PIX_W-1:0] mix_pix;

  comp_backdrop_gen i_bdgen (
    .is_bd   (base_is_bd),
    .hbl     (hblank),
    .vbl     (vblank),
    .disp_on (disp_en),
    .bd_now  (bd_now)
  );

  comp_layer_sel #(.CH_W(CH_W), .NCH(NCH)) i_sel (
    .base_pix (base_pix),
    .ovl_pix  (ovl_pix),
    .ovl_prio (ovl_prio),
    .bd_now   (bd_now),
    .opaque   (ovl_opaque),
    .sel_ovl  (sel_now),
    .mix_pix  (mix_pix)
  );

  comp_out_stage #(.PIX_W(PIX_W)) i_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .mix_pix     (mix_pix),
    .bd_now      (bd_now),
    .sel_ovl     (sel_now),
    .out_pix     (out_pix),
    .bd_n        (bd_n),
    .out_ovl_sel (out_ovl_sel)
  );
endmodule

// File: rtl/layer_compositor_chk.sv
module layer_compositor_chk #(
  parameter int PIX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PIX_W-1:0] base_pix,
  input logic             base_is_bd,
  input logic             hblank,
  input logic             vblank,
  input logic             disp_en,
  input logic [PIX_W-1:0] ovl_pix,
  input logic             ovl_prio,
  input logic [PIX_W-1:0] out_pix,
  input logic             bd_n,
  input logic             out_ovl_sel,
  input logic             bd_now,
  input logic             sel_now
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_bd_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(base_is_bd) |-> !bd_n);
  p_bd_hblank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(hblank) |-> !bd_n);
  p_bd_vblank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(vblank) |-> !bd_n);
  p_bd_dispoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!disp_en) |-> !bd_n);
  p_bd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!base_is_bd && !hblank && !vblank && disp_en) |-> bd_n);
  p_prio_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(ovl_prio && (ovl_pix != '0)) |-> out_ovl_sel);
  // R8 and R9: a low-priority opaque overlay follows the aligned indicator.
  p_low_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!ovl_prio && (ovl_pix != '0)) |-> (out_ovl_sel == !bd_n));
  p_transparent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(ovl_pix == '0) |-> !out_ovl_sel);
  p_align_ovl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    armed && out_ovl_sel |-> (out_pix == $past(ovl_pix)));
  p_align_base_r11: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !out_ovl_sel |-> (out_pix == $past(base_pix)));
  p_sel_reg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_ovl_sel == $past(sel_now)) && (bd_n == !$past(bd_now)));
endmodule

bind layer_compositor layer_compositor_chk #(.PIX_W(PIX_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .base_pix    (base_pix),
  .base_is_bd  (base_is_bd),
  .hblank      (hblank),
  .vblank      (vblank),
  .disp_en     (disp_en),
  .ovl_pix     (ovl_pix),
  .ovl_prio    (ovl_prio),
  .out_pix     (out_pix),
  .bd_n        (bd_n),
  .out_ovl_sel (out_ovl_sel),
  .bd_now      (bd_now),
  .sel_now     (sel_now)
);

// File: tb/test_layer_compositor.sv
module test_layer_compositor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] base_pix = '0;
  logic       base_is_bd = 1'b0;
  logic       hblank = 1'b0;
  logic       vblank = 1'b0;
  logic       disp_en = 1'b1;
  logic [8:0] ovl_pix = '0;
  logic       ovl_prio = 1'b0;
  logic [8:0] out_pix;
  logic       bd_n;
  logic       out_ovl_sel;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  layer_compositor i_layer_compositor (
    .clk(clk), .rst_n(rst_n), .base_pix(base_pix), .base_is_bd(base_is_bd),
    .hblank(hblank), .vblank(vblank), .disp_en(disp_en), .ovl_pix(ovl_pix),
    .ovl_prio(ovl_prio), .out_pix(out_pix), .bd_n(bd_n), .out_ovl_sel(out_ovl_sel)
  );

  // Drive at a falling edge, let one rising edge register it, check at next falling edge.
  task automatic step_check(input logic [8:0] b, input logic bdf, input logic hb,
                            input logic vb, input logic de, input logic [8:0] o,
                            input logic pr, input string req);
    logic       e_bd, e_sel;
    logic [8:0] e_pix;
    base_pix = b; base_is_bd = bdf; hblank = hb; vblank = vb; disp_en = de;
    ovl_pix = o; ovl_prio = pr;
    // Expected values from the requirement text
    e_bd  = bdf || hb || vb || !de;
    e_sel = (o != 9'h000) && (pr || e_bd);
    e_pix = e_sel ? o : b;
    @(negedge clk);
    checks++;
    if (bd_n !== !e_bd || out_ovl_sel !== e_sel || out_pix !== e_pix) begin
      fails++;
      $display("FAIL %s: got bd_n=%b sel=%b pix=%h, expected bd_n=%b sel=%b pix=%h",
               req, bd_n, out_ovl_sel, out_pix, !e_bd, e_sel, e_pix);
    end
  endtask

  task automatic t_reset;
    checks++;
    if (out_pix !== 9'h000 || bd_n !== 1'b1 || out_ovl_sel !== 1'b0) begin
      fails++;
      $display("FAIL R1: got pix=%h bd_n=%b sel=%b, expected pix=000 bd_n=1 sel=0",
               out_pix, bd_n, out_ovl_sel);
    end
  endtask

  task automatic t_indicator;
    step_check(9'h1A5, 1'b0, 1'b0, 1'b0, 1'b1, 9'h000, 1'b0, "R6 visible base");
    step_check(9'h049, 1'b1, 1'b0, 1'b0, 1'b1, 9'h000, 1'b0, "R2 backdrop flag");
    step_check(9'h1A5, 1'b0, 1'b1, 1'b0, 1'b1, 9'h000, 1'b0, "R3 hblank");
    step_check(9'h1A5, 1'b0, 1'b0, 1'b1, 1'b1, 9'h000, 1'b0, "R4 vblank");
    step_check(9'h1A5, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 1'b0, "R5 display off");
    step_check(9'h0F0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h000, 1'b0, "R6 cleared again");
  endtask

  task automatic t_priority;
    step_check(9'h1FF, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0C3, 1'b1, "R7 prio over visible base");
    step_check(9'h049, 1'b1, 1'b0, 1'b0, 1'b1, 9'h155, 1'b1, "R7 prio over backdrop");
    step_check(9'h049, 1'b1, 1'b0, 1'b0, 1'b1, 9'h0AA, 1'b0, "R8 low prio on backdrop");
    step_check(9'h1A5, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0AA, 1'b0, "R9 low prio loses");
    step_check(9'h1A5, 1'b0, 1'b0, 1'b0, 1'b1, 9'h001, 1'b0, "R9 low prio blue lsb");
  endtask

  // Indicator forced by blanking or display-off meets low-priority or transparent overlay.
  task automatic t_coincide;
    step_check(9'h1A5, 1'b0, 1'b1, 1'b0, 1'b1, 9'h111, 1'b0, "R8 low prio in hblank");
    step_check(9'h1A5, 1'b0, 1'b0, 1'b1, 1'b1, 9'h122, 1'b0, "R8 low prio in vblank");
    step_check(9'h1A5, 1'b0, 1'b0, 1'b0, 1'b0, 9'h133, 1'b0, "R8 low prio display off");
    step_check(9'h1A5, 1'b0, 1'b0, 1'b0, 1'b1, 9'h000, 1'b1, "R10 transparent with prio");
    step_check(9'h049, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000, 1'b1, "R10 transparent on backdrop");
    step_check(9'h100, 1'b0, 1'b0, 1'b0, 1'b1, 9'h100, 1'b0, "R9 red msb low prio");
  endtask

  // Back-to-back mixed stimulus: every cycle must line up one clock later.
  task automatic t_stream;
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 64; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step_check(lfsr[8:0], lfsr[9], lfsr[10] & lfsr[11], lfsr[12] & lfsr[13],
                 ~(lfsr[14] & lfsr[15] & lfsr[9]),
                 (lfsr[3:0] == 4'h0) ? 9'h000 : {lfsr[2:0], lfsr[15:10]},
                 lfsr[5], "R11 stream alignment");
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_indicator();
    t_priority();
    t_coincide();
    t_stream();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule